// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block keeps two banks of address translation windows, one for inbound traffic and one for outbound traffic. Each bank holds `NWIN` windows, and `NWIN` is at most 16. Software reaches every window through a single shared group of registers. A selector register chooses the bank and the window index that the group addresses. Each window holds a 64-bit base, a 32-bit limit, a 64-bit target, a type word and a control word whose top bit enables the window.

Writes to any window register except control only stage a value. Writing the control register commits all of the window's staged fields, together with the new control word, into the copy that the lookup uses.

The lookup path is combinational. It takes an address and a direction and reports the following:
- whether an enabled window matched;
- which window matched;
- the translated address;
- whether the match is a memory window or a configuration window.

A memory window adds the offset from the base to the target. A configuration window returns the bus and device/function numbers taken from the target, plus the offset trimmed to the size of a configuration space.

Top module: `xlat_window_unit`

## Requirements
- R1: The selector register is at offset 0x900. Bits [3:0] hold the window index, and bit 31 selects the inbound bank when 1 and the outbound bank when 0. Reading it returns only those bits, with all other bits 0.
- R2: The window registers sit at these offsets: type 0x904, control 0x908, base low 0x90C, base high 0x910, limit 0x914, target low 0x918, target high 0x91C. A read returns the staged value of the selected window.
- R3: A write to a window register other than control does not change the lookup. A write to control commits every staged field of that window, and the lookup reflects it from the next clock cycle on.
- R4: After reset, every window has base 0, target 0, limit 0xFFFFFFFF and type 0. Inbound window 0 has control 0x80000000 (enabled), and all other windows have control 0.
- R5: A window matches addresses from its base up to and including {base[63:32], limit}.
- R6: For a memory window (type 0), the translated address is target + (address − base).
- R7: For a configuration window (any nonzero type), `lk_is_cfg` is 1. The bus number is target[31:24], the device/function is target[23:16], and the translated address is (address − base) masked to the low `CFG_BITS` bits (default 12).
- R8: When several enabled windows of the selected bank match, the lowest-numbered one wins.
- R9: On a miss, `lk_hit`, `lk_win`, `lk_is_cfg`, `lk_bus` and `lk_devfn` are all 0, and the translated address equals the input address.
- R10: A window whose committed control bit 31 is 0 never matches.
- R11: If the selected index is `NWIN` or more, writes to window registers are ignored and reads return 0. A read of an offset that maps to no register also returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_addr | input | 64 | Address to translate |
| lk_inbound | input | 1 | 1 = inbound bank, 0 = outbound bank |
| lk_hit | output | 1 | An enabled window matched |
| lk_win | output | 4 | Index of the matching window |
| lk_xaddr | output | 64 | Translated address |
| lk_is_cfg | output | 1 | The match is a configuration window |
| lk_bus | output | 8 | Bus number for a configuration match |
| lk_devfn | output | 8 | Device/function for a configuration match |

## Verification
The hardest case to reach from the ports is a window whose staged and committed contents differ, because a readback shows only the staged side. The bench programs a window, commits it, and then rewrites its base without touching control. It then confirms that the lookup still follows the old base. A control write must be the only thing that moves the match. Overlapping windows are built on purpose, and the lower one is then disabled, so that priority and the enable bit are both seen changing the winner.

// File: rtl/xwu_pkg.sv
// Package: shared register offsets, window record and reset defaults for
// the translation window unit. Assumes a 12-bit byte register offset.
package xwu_pkg;
    localparam logic [11:0] OFS_VP     = 12'h900;
    localparam logic [11:0] OFS_TYPE   = 12'h904;
    localparam logic [11:0] OFS_CTRL   = 12'h908;
    localparam logic [11:0] OFS_BASE_L = 12'h90C;
    localparam logic [11:0] OFS_BASE_H = 12'h910;
    localparam logic [11:0] OFS_LIMIT  = 12'h914;
    localparam logic [11:0] OFS_TGT_L  = 12'h918;
    localparam logic [11:0] OFS_TGT_H  = 12'h91C;
    localparam int          EN_BIT     = 31;

    typedef struct packed {
        logic [63:0] base;
        logic [31:0] limit;
        logic [63:0] target;
        logic [31:0] wtype;
        logic [31:0] ctrl;
    } win_t;

    // Reset content of a window; only inbound window 0 starts enabled.
    function automatic win_t win_default(input logic inbound, input int idx);
        win_t w;
        w.base   = '0;
        w.limit  = 32'hFFFF_FFFF;
        w.target = '0;
        w.wtype  = '0;
        w.ctrl   = (inbound && idx == 0) ? 32'h8000_0000 : 32'h0;
        return w;
    endfunction
endpackage

// File: rtl/xwu_window_bank.sv
// Window storage for both directions: a staged copy that software writes
// and reads, and a committed copy used by lookup. Assumes the caller
// has already decoded the selector into bank and index.
module xwu_window_bank
    import xwu_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [11:0]       offset,
    input  logic [31:0]       wdata,
    input  logic [3:0]        sel_idx,
    input  logic              sel_in,
    output logic [31:0]       rdata,
    output win_t [NWIN-1:0]   act_out,
    output win_t [NWIN-1:0]   act_in
);
    localparam int NBANK = 2;

    win_t [NWIN-1:0] stg [NBANK];
    win_t [NWIN-1:0] act [NBANK];
    logic            sel_ok;

    // Selected index must address an existing window.
    assign sel_ok = ({28'd0, sel_idx} < 32'(NWIN));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar i = 0; i < NWIN; i++) begin : g_win
            logic hit_sel;
            assign hit_sel = we && sel_ok && (sel_in == b[0]) && (sel_idx == 4'(i));

            // Staged fields: updated by any window register write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[b][i] <= win_default(b[0], i);
                end else if (hit_sel) begin
                    case (offset)
                        OFS_TYPE:   stg[b][i].wtype         <= wdata;
                        OFS_CTRL:   stg[b][i].ctrl          <= wdata;
                        OFS_BASE_L: stg[b][i].base[31:0]    <= wdata;
                        OFS_BASE_H: stg[b][i].base[63:32]   <= wdata;
                        OFS_LIMIT:  stg[b][i].limit         <= wdata;
                        OFS_TGT_L:  stg[b][i].target[31:0]  <= wdata;
                        OFS_TGT_H:  stg[b][i].target[63:32] <= wdata;
                        default: ;
                    endcase
                end
            end

            // Committed copy: loaded only by a control write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act[b][i] <= win_default(b[0], i);
                end else if (hit_sel && offset == OFS_CTRL) begin
                    act[b][i]      <= stg[b][i];
                    act[b][i].ctrl <= wdata;
                end
            end
        end
    end

    assign act_out = act[0];
    assign act_in  = act[1];

    // Readback mux over the staged copy of the selected window.
    always_comb begin
        win_t w;
        w     = stg[sel_in ? 1 : 0][sel_ok ? sel_idx : 4'd0];
        rdata = '0;
        if (sel_ok) begin
            case (offset)
                OFS_TYPE:   rdata = w.wtype;
                OFS_CTRL:   rdata = w.ctrl;
                OFS_BASE_L: rdata = w.base[31:0];
                OFS_BASE_H: rdata = w.base[63:32];
                OFS_LIMIT:  rdata = w.limit;
                OFS_TGT_L:  rdata = w.target[31:0];
                OFS_TGT_H:  rdata = w.target[63:32];
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/xwu_match.sv
// Priority match of one address against one bank of committed windows.
// Produces hit, index and translation. Assumes NWIN <= 16.
module xwu_match
    import xwu_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int CFG_BITS = 12
) (
    input  win_t [NWIN-1:0] wins,
    input  logic [63:0]     addr,
    output logic            hit,
    output logic [3:0]      win,
    output logic [63:0]     xaddr,
    output logic            is_cfg,
    output logic [7:0]      bus,
    output logic [7:0]      devfn
);
    localparam logic [63:0] CFG_MASK = (64'd1 << CFG_BITS) - 64'd1;

    // Scan from the top index down so the lowest matching window wins.
    always_comb begin
        logic [63:0] off;
        logic [63:0] upper;
        hit    = 1'b0;
        win    = '0;
        xaddr  = addr;
        is_cfg = 1'b0;
        bus    = '0;
        devfn  = '0;
        off    = '0;
        upper  = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            upper = {wins[i].base[63:32], wins[i].limit};
            if (wins[i].ctrl[EN_BIT] && addr >= wins[i].base && addr <= upper) begin
                off = addr - wins[i].base;
                hit = 1'b1;
                win = 4'(i);
                if (wins[i].wtype == 32'd0) begin
                    xaddr  = wins[i].target + off;
                    is_cfg = 1'b0;
                    bus    = '0;
                    devfn  = '0;
                end else begin
                    xaddr  = off & CFG_MASK;
                    is_cfg = 1'b1;
                    bus    = wins[i].target[31:24];
                    devfn  = wins[i].target[23:16];
                end
            end
        end
    end
endmodule

// File: rtl/xlat_window_unit.sv
// Top of the translation window unit: selector register, window storage
// and one matcher per direction. Assumes NWIN <= 16 and 32-bit register
// accesses at aligned offsets.
module xlat_window_unit
    import xwu_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int CFG_BITS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [63:0] lk_addr,
    input  logic        lk_inbound,
    output logic        lk_hit,
    output logic [3:0]  lk_win,
    output logic [63:0] lk_xaddr,
    output logic        lk_is_cfg,
    output logic [7:0]  lk_bus,
    output logic [7:0]  lk_devfn
);
    localparam int NBANK = 2;

    logic [3:0]      vp_idx;
    logic            vp_in;
    logic [31:0]     win_rdata;
    win_t [NWIN-1:0] act_out;
    win_t [NWIN-1:0] act_in;

    logic        m_hit   [NBANK];
    logic [3:0]  m_win   [NBANK];
    logic [63:0] m_xaddr [NBANK];
    logic        m_cfg   [NBANK];
    logic [7:0]  m_bus   [NBANK];
    logic [7:0]  m_devfn [NBANK];

    // Selector register: window index and bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vp_idx <= '0;
            vp_in  <= 1'b0;
        end else if (reg_we && reg_addr == OFS_VP) begin
            vp_idx <= reg_wdata[3:0];
            vp_in  <= reg_wdata[31];
        end
    end

    xwu_window_bank #(.NWIN(NWIN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .offset  (reg_addr),
        .wdata   (reg_wdata),
        .sel_idx (vp_idx),
        .sel_in  (vp_in),
        .rdata   (win_rdata),
        .act_out (act_out),
        .act_in  (act_in)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_match
        xwu_match #(.NWIN(NWIN), .CFG_BITS(CFG_BITS)) u_match (
            .wins   (b == 1 ? act_in : act_out),
            .addr   (lk_addr),
            .hit    (m_hit[b]),
            .win    (m_win[b]),
            .xaddr  (m_xaddr[b]),
            .is_cfg (m_cfg[b]),
            .bus    (m_bus[b]),
            .devfn  (m_devfn[b])
        );
    end

    // Direction select of the lookup result.
    always_comb begin
        int s;
        s         = lk_inbound ? 1 : 0;
        lk_hit    = m_hit[s];
        lk_win    = m_win[s];
        lk_xaddr  = m_xaddr[s];
        lk_is_cfg = m_cfg[s];
        lk_bus    = m_bus[s];
        lk_devfn  = m_devfn[s];
    end

    // Register read mux: selector first, then window registers.
    assign reg_rdata = (reg_addr == OFS_VP) ? {vp_in, 27'd0, vp_idx} : win_rdata;
endmodule

// File: rtl/xwu_checker.sv
// Checker for the translation window unit, bound to every instance of the
// top. Relates register writes, readback and lookup outputs over time.
module xwu_checker
    import xwu_pkg::*;
#(
    parameter int NWIN     = 4,
    parameter int CFG_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [63:0] lk_addr,
    input logic        lk_inbound,
    input logic        lk_hit,
    input logic [3:0]  lk_win,
    input logic [63:0] lk_xaddr,
    input logic        lk_is_cfg,
    input logic [7:0]  lk_bus,
    input logic [7:0]  lk_devfn
);
    AST_VP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_VP) ##1 (reg_addr == OFS_VP)
        |-> reg_rdata == {$past(reg_wdata[31]), 27'd0, $past(reg_wdata[3:0])}); // R1

    AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr != OFS_CTRL) ##1 ($stable(lk_addr) && $stable(lk_inbound))
        |-> ($stable(lk_hit) && $stable(lk_xaddr) && $stable(lk_win) && $stable(lk_is_cfg))); // R3

    AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_xaddr == lk_addr && !lk_is_cfg && lk_win == 4'd0)); // R9

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ({28'd0, lk_win} < 32'(NWIN))); // R8

    AST_CFG_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_is_cfg) |-> ((lk_xaddr >> CFG_BITS) == 64'd0)); // R7

    AST_MEM_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_is_cfg |-> (lk_bus == 8'd0 && lk_devfn == 8'd0)); // R6
endmodule

bind xlat_window_unit xwu_checker #(.NWIN(NWIN), .CFG_BITS(CFG_BITS)) u_chk (.*);

// File: tb/xlat_window_unit_tb.sv
module xlat_window_unit_tb;
    import xwu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NWIN       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] lk_addr = '0;
    logic        lk_inbound = 1'b0;
    logic        lk_hit;
    logic [3:0]  lk_win;
    logic [63:0] lk_xaddr;
    logic        lk_is_cfg;
    logic [7:0]  lk_bus;
    logic [7:0]  lk_devfn;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_window_unit #(.NWIN(NWIN), .CFG_BITS(12)) u_dut (.*);

    typedef struct packed {
        logic        inb;
        logic [63:0] a;
        logic        hit;
        logic [3:0]  w;
        logic [63:0] x;
        logic        cfg;
        logic [7:0]  bus;
        logic [7:0]  dfn;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 64'h1_0000_0010, 1'b1, 4'd1, 64'h80_0000_0010, 1'b0, 8'h00, 8'h00}, // R6
        '{1'b0, 64'h1_0000_8004, 1'b1, 4'd0, 64'h0_5000_0004,  1'b0, 8'h00, 8'h00}, // R8
        '{1'b0, 64'h1_0000_FFFF, 1'b1, 4'd1, 64'h80_0000_FFFF, 1'b0, 8'h00, 8'h00}, // R5
        '{1'b0, 64'h1_0001_0000, 1'b0, 4'd0, 64'h1_0001_0000,  1'b0, 8'h00, 8'h00}, // R9
        '{1'b0, 64'h0_4000_1234, 1'b1, 4'd2, 64'h0_0000_0234,  1'b1, 8'h03, 8'h05}, // R7
        '{1'b0, 64'h0_3FFF_FFFF, 1'b0, 4'd0, 64'h0_3FFF_FFFF,  1'b0, 8'h00, 8'h00}, // R5
        '{1'b1, 64'h0_1234_5678, 1'b1, 4'd0, 64'h0_1234_5678,  1'b0, 8'h00, 8'h00}, // R4
        '{1'b1, 64'h1_0000_0000, 1'b0, 4'd0, 64'h1_0000_0000,  1'b0, 8'h00, 8'h00}  // R5
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic look(input logic inb, input logic [63:0] a);
        lk_inbound = inb; lk_addr = a;
        #1;
    endtask

    task automatic prog(input logic inb, input int idx, input logic [31:0] typ,
                        input logic [63:0] base, input logic [31:0] lim,
                        input logic [63:0] tgt, input logic [31:0] ctrl);
        wr(OFS_VP, {inb, 27'd0, 4'(idx)});
        wr(OFS_TYPE, typ);
        wr(OFS_BASE_L, base[31:0]);
        wr(OFS_BASE_H, base[63:32]);
        wr(OFS_LIMIT, lim);
        wr(OFS_TGT_L, tgt[31:0]);
        wr(OFS_TGT_H, tgt[63:32]);
        wr(OFS_CTRL, ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset state
        rd(OFS_VP, d);     check("R4 vp reset", 64'(d), 64'h0);
        wr(OFS_VP, 32'h8000_0000);
        rd(OFS_VP, d);     check("R1 vp readback", 64'(d), 64'h8000_0000);
        rd(OFS_CTRL, d);   check("R4 in0 ctrl", 64'(d), 64'h8000_0000);
        rd(OFS_LIMIT, d);  check("R4 in0 limit", 64'(d), 64'hFFFF_FFFF);
        look(1'b0, 64'h10);
        check("R4 outbound off at reset", 64'(lk_hit), 64'h0);

        // Program outbound windows 0,1,2
        prog(1'b0, 1, 32'd0, 64'h1_0000_0000, 32'h0000_FFFF, 64'h80_0000_0000, 32'h8000_0000);
        prog(1'b0, 0, 32'd0, 64'h1_0000_8000, 32'h0000_8FFF, 64'h0_5000_0000, 32'h8000_0000);
        prog(1'b0, 2, 32'd4, 64'h0_4000_0000, 32'h4FFF_FFFF, 64'h0_0305_0000, 32'h8000_0000);

        // R2: readback of selected window staged fields
        wr(OFS_VP, 32'h0000_0002);
        rd(OFS_TYPE, d);   check("R2 type readback", 64'(d), 64'h4);
        rd(OFS_TGT_L, d);  check("R2 target low readback", 64'(d), 64'h0305_0000);
        rd(12'h920, d);    check("R11 unmapped offset", 64'(d), 64'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            look(VEC[i].inb, VEC[i].a);
            check($sformatf("R5/R6/R7/R8/R9 vec%0d hit", i), 64'(lk_hit), 64'(VEC[i].hit));
            check($sformatf("R8 vec%0d win", i), 64'(lk_win), 64'(VEC[i].w));
            check($sformatf("R6 vec%0d xaddr", i), lk_xaddr, VEC[i].x);
            check($sformatf("R7 vec%0d cfg", i), 64'(lk_is_cfg), 64'(VEC[i].cfg));
            check($sformatf("R7 vec%0d bus", i), 64'(lk_bus), 64'(VEC[i].bus));
            check($sformatf("R7 vec%0d devfn", i), 64'(lk_devfn), 64'(VEC[i].dfn));
        end

        // R10: disable window 0; overlap now resolved by window 1
        wr(OFS_VP, 32'h0000_0000);
        wr(OFS_CTRL, 32'h0000_0000);
        look(1'b0, 64'h1_0000_8004);
        check("R10 disabled win0 win", 64'(lk_win), 64'h1);
        check("R10 disabled win0 xaddr", lk_xaddr, 64'h80_0000_8004);

        // R3: staged base write does not move lookup until control write
        wr(OFS_VP, 32'h0000_0001);
        wr(OFS_BASE_L, 32'h0000_0100);
        look(1'b0, 64'h1_0000_0010);
        check("R3 staged only hit", 64'(lk_hit), 64'h1);
        check("R3 staged only xaddr", lk_xaddr, 64'h80_0000_0010);
        wr(OFS_CTRL, 32'h8000_0000);
        look(1'b0, 64'h1_0000_0010);
        check("R3 committed miss", 64'(lk_hit), 64'h0);
        look(1'b0, 64'h1_0000_0110);
        check("R3 committed xaddr", lk_xaddr, 64'h80_0000_0010);

        // R11: index beyond NWIN ignores writes, reads zero
        wr(OFS_VP, 32'h0000_0005);
        wr(OFS_LIMIT, 32'h1234_5678);
        rd(OFS_LIMIT, d);  check("R11 out of range read", 64'(d), 64'h0);
        wr(OFS_VP, 32'h0000_0003);
        rd(OFS_LIMIT, d);  check("R11 win3 untouched", 64'(d), 64'hFFFF_FFFF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule